// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block counts pulses of a slow, free-running tick (presented as a clock enable in the system clock domain). If software fails to service it in time, the block asks for a system reset. The count runs in two stages. The first stage divides the tick by 32 or by 128. The second stage divides the result by a power of two from 1 to 32768. The full timeout period T is therefore 32·2^s or 128·2^s ticks, where s is the 4-bit postscale select.

A timeout raises a one-cycle reset request. If the chip is in sleep or idle at that moment, it raises a one-cycle wake-up request instead. A timeout also sets a sticky flag that software must clear. An optional windowed mode limits the service (clear) command to the last quarter of the period; a clear that arrives earlier is itself treated as a fault and produces a reset request. Several system events restart the count from zero: the clear command, entry to a power-save mode, exit from sleep or idle, a completed clock switch, and a system reset.

The block runs whenever the hardware enable configuration bit is set. When that bit is clear, it runs only while a software enable bit, written through a write strobe, is set. All inputs and outputs are plain control and status pins; the block has no streaming data path, so no valid/ready handshake applies.

Top module: `guard_timer`

## Requirements
- R1: With `cfg_long_pre` = 0 the first stage divides the tick by 32; with `cfg_long_pre` = 1 it divides by 128.
- R2: The second stage divides by 2^`cfg_post_sel`, giving a period T of (32 or 128)·2^sel accepted ticks. A cycle with `tick_en` low does not advance the count.
- R3: A pulse on any of `clr_cmd`, `pwrsave_enter`, `sleep_exit`, `clk_switch_done` or `sys_rst` returns both stages to zero. The next timeout then comes exactly T accepted ticks after the edge that took the pulse.
- R4: The block runs while `cfg_hw_en` = 1 or the software enable bit = 1. The software enable bit is written from `sw_en_val` on a `sw_en_wr` pulse. While the block is not running, the count is held at zero and no request is raised, even on a clear command.
- R5: A `sys_rst` pulse forces the software enable bit to 0, and it wins over a write in the same cycle.
- R6: The timeout is taken at the clock edge that accepts the T-th tick. At that edge a one-cycle pulse appears on `rst_req` when `in_sleep` = 0, or on `wake_req` when `in_sleep` = 1, and the count restarts from zero.
- R7: With `cfg_win_off` = 0, a clear command while fewer than 3T/4 ticks have elapsed raises `rst_req` on the next edge and restarts the count. A clear command at 3T/4 or later only restarts the count. With `cfg_win_off` = 1, every clear command only restarts the count.
- R8: `timeout_flag` is set by every timeout and stays set until a `flag_clr` pulse. A timeout in the same cycle as `flag_clr` leaves the flag set. A system reset pulse does not clear it.
- R9: When a restart pulse (R3) falls in the same cycle as the terminal tick, the restart wins: no request is raised and the flag is not set.
- R10: After `rst_n` is released, `rst_req`, `wake_req` and `timeout_flag` are 0 and the software enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per slow tick |
| cfg_long_pre | input | 1 | First-stage divisor: 0 selects 32, 1 selects 128 |
| cfg_post_sel | input | SEL_W | Second-stage divisor exponent |
| cfg_hw_en | input | 1 | Hardware enable, keeps the block running |
| cfg_win_off | input | 1 | 1 turns windowed clear mode off |
| sw_en_wr | input | 1 | Write strobe for the software enable bit |
| sw_en_val | input | 1 | Value written to the software enable bit |
| clr_cmd | input | 1 | Service (clear) command pulse |
| pwrsave_enter | input | 1 | Power-save entry pulse |
| sleep_exit | input | 1 | Sleep or idle exit pulse |
| clk_switch_done | input | 1 | Clock switch completion pulse |
| sys_rst | input | 1 | System reset event pulse |
| in_sleep | input | 1 | High while the chip is in sleep or idle |
| flag_clr | input | 1 | Software clear of the timeout flag |
| rst_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| timeout_flag | output | 1 | Sticky timeout indication |

## Verification
Two events can land on the same clock edge: a service command and the terminal tick that would expire the period. The bench provokes this by issuing the clear exactly T−1 ticks after a restart, with windowed mode on so the clear is also legal. The scoreboard then requires silence at that edge and a single reset request a full period later. A second pair that can coincide is an early clear and the window boundary. The bench places clears one tick before and exactly at 3T/4 for two period settings, and requires a reset request in the first case only.

// File: rtl/gt_pkg.sv
package gt_pkg;

  typedef enum logic [1:0] {
    GT_QUIET    = 2'd0,
    GT_HARD_RST = 2'd1,
    GT_WAKEUP   = 2'd2
  } gt_outcome_e;

  // An illegal early service always forces a reset; an expiry resets or
  // wakes depending on the power state.
  function automatic gt_outcome_e gt_resolve(input logic early_clr,
                                             input logic expired,
                                             input logic asleep);
    if (early_clr) return GT_HARD_RST;
    if (expired)   return asleep ? GT_WAKEUP : GT_HARD_RST;
    return GT_QUIET;
  endfunction

endpackage

// File: rtl/gt_prescale.sv
module gt_prescale #(
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 adv,
  input  logic                 long_sel,
  output logic [LONG_LOG2-1:0] cnt,
  output logic                 wrap
);

  localparam logic [LONG_LOG2-1:0] LIM_LONG  = '1;
  localparam logic [LONG_LOG2-1:0] LIM_SHORT = LONG_LOG2'((1 << SHORT_LOG2) - 1);

  logic [LONG_LOG2-1:0] lim;

  assign lim  = long_sel ? LIM_LONG : LIM_SHORT;
  assign wrap = adv && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (adv)    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/gt_postscale.sv
module gt_postscale #(
  parameter int SEL_W = 4,
  localparam int QW   = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [SEL_W-1:0] sel,
  output logic [QW-1:0]    cnt,
  output logic             term
);

  // Terminal value 2^sel - 1: bit i is set for every i below sel.
  logic [QW-1:0] lim;

  for (genvar i = 0; i < QW; i++) begin : g_lim
    assign lim[i] = (int'(sel) > i);
  end

  assign term = adv && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (term)   cnt <= '0;
    else if (adv)    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/gt_window.sv
module gt_window #(
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 7,
  parameter int SEL_W      = 4,
  localparam int QW        = (1 << SEL_W) - 1,
  localparam int CW        = LONG_LOG2 + QW,
  localparam int GAP       = LONG_LOG2 - SHORT_LOG2
) (
  input  logic [LONG_LOG2-1:0] pre_cnt,
  input  logic [QW-1:0]        post_cnt,
  input  logic                 long_sel,
  input  logic [SEL_W-1:0]     sel,
  output logic                 in_window
);

  logic [CW-1:0] elapsed;
  logic [CW:0]   span;
  logic [CW:0]   thresh;

  if (GAP > 0) begin : g_two_widths
    assign elapsed = long_sel ? {post_cnt, pre_cnt}
                              : {{GAP{1'b0}}, post_cnt, pre_cnt[SHORT_LOG2-1:0]};
  end else begin : g_one_width
    logic unused_sel;
    assign unused_sel = long_sel;
    assign elapsed    = {post_cnt, pre_cnt};
  end

  assign span      = (CW+1)'(1) << (int'(sel) + (long_sel ? LONG_LOG2 : SHORT_LOG2));
  assign thresh    = span - (span >> 2);
  assign in_window = ({1'b0, elapsed} >= thresh);

endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gt_pkg::*;
#(
  parameter int PRE_SHORT_LOG2 = 5,
  parameter int PRE_LONG_LOG2  = 7,
  parameter int SEL_W          = 4,
  localparam int QW            = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cfg_long_pre,
  input  logic [SEL_W-1:0] cfg_post_sel,
  input  logic             cfg_hw_en,
  input  logic             cfg_win_off,
  input  logic             sw_en_wr,
  input  logic             sw_en_val,
  input  logic             clr_cmd,
  input  logic             pwrsave_enter,
  input  logic             sleep_exit,
  input  logic             clk_switch_done,
  input  logic             sys_rst,
  input  logic             in_sleep,
  input  logic             flag_clr,
  output logic             rst_req,
  output logic             wake_req,
  output logic             timeout_flag
);

  logic                     sw_en_q;
  logic                     running;
  logic                     restart_evt;
  logic                     cnt_clear;
  logic                     adv;
  logic [PRE_LONG_LOG2-1:0] pre_cnt;
  logic                     pre_wrap;
  logic [QW-1:0]            post_cnt;
  logic                     post_term;
  logic                     win_open;
  logic                     expired;
  logic                     early_clr;
  gt_outcome_e              outcome;

  assign running     = cfg_hw_en | sw_en_q;
  assign restart_evt = clr_cmd | pwrsave_enter | sleep_exit | clk_switch_done | sys_rst;
  assign cnt_clear   = restart_evt | ~running;
  assign adv         = tick_en & running;

  gt_prescale #(
    .SHORT_LOG2 (PRE_SHORT_LOG2),
    .LONG_LOG2  (PRE_LONG_LOG2)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .adv      (adv),
    .long_sel (cfg_long_pre),
    .cnt      (pre_cnt),
    .wrap     (pre_wrap)
  );

  gt_postscale #(
    .SEL_W (SEL_W)
  ) u_post (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cnt_clear),
    .adv   (pre_wrap),
    .sel   (cfg_post_sel),
    .cnt   (post_cnt),
    .term  (post_term)
  );

  gt_window #(
    .SHORT_LOG2 (PRE_SHORT_LOG2),
    .LONG_LOG2  (PRE_LONG_LOG2),
    .SEL_W      (SEL_W)
  ) u_win (
    .pre_cnt   (pre_cnt),
    .post_cnt  (post_cnt),
    .long_sel  (cfg_long_pre),
    .sel       (cfg_post_sel),
    .in_window (win_open)
  );

  // A restart in the same cycle as the terminal tick cancels the expiry.
  assign expired   = post_term & ~restart_evt;
  assign early_clr = running & clr_cmd & ~cfg_win_off & ~win_open;
  assign outcome   = gt_resolve(early_clr, expired, in_sleep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sw_en_q <= 1'b0;
    else if (sys_rst)  sw_en_q <= 1'b0;
    else if (sw_en_wr) sw_en_q <= sw_en_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req      <= 1'b0;
      wake_req     <= 1'b0;
      timeout_flag <= 1'b0;
    end else begin
      rst_req      <= (outcome == GT_HARD_RST);
      wake_req     <= (outcome == GT_WAKEUP);
      timeout_flag <= expired | (timeout_flag & ~flag_clr);
    end
  end

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic running,
  input logic clr_cmd,
  input logic in_sleep,
  input logic flag_clr,
  input logic rst_req,
  input logic wake_req,
  input logic timeout_flag
);

  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake_req)); // R6

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req); // R6

  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(in_sleep)); // R6

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (!rst_req && !wake_req)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !flag_clr) |=> timeout_flag); // R8

  AST_WAKE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> timeout_flag); // R8

  AST_CLR_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> !wake_req); // R9

endmodule

bind guard_timer guard_timer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .running      (running),
  .clr_cmd      (clr_cmd),
  .in_sleep     (in_sleep),
  .flag_clr     (flag_clr),
  .rst_req      (rst_req),
  .wake_req     (wake_req),
  .timeout_flag (timeout_flag)
);

// File: tb/sim_guard_timer.sv
module sim_guard_timer;

  localparam int SEL_W = 4;
  localparam int K_RST = 1;
  localparam int K_WAKE = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic             tick_en;
  logic             cfg_long_pre;
  logic [SEL_W-1:0] cfg_post_sel;
  logic             cfg_hw_en;
  logic             cfg_win_off;
  logic             sw_en_wr;
  logic             sw_en_val;
  logic             clr_cmd;
  logic             pwrsave_enter;
  logic             sleep_exit;
  logic             clk_switch_done;
  logic             sys_rst;
  logic             in_sleep;
  logic             flag_clr;
  logic             rst_req;
  logic             wake_req;
  logic             timeout_flag;

  guard_timer #(.SEL_W(SEL_W)) u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick_en         (tick_en),
    .cfg_long_pre    (cfg_long_pre),
    .cfg_post_sel    (cfg_post_sel),
    .cfg_hw_en       (cfg_hw_en),
    .cfg_win_off     (cfg_win_off),
    .sw_en_wr        (sw_en_wr),
    .sw_en_val       (sw_en_val),
    .clr_cmd         (clr_cmd),
    .pwrsave_enter   (pwrsave_enter),
    .sleep_exit      (sleep_exit),
    .clk_switch_done (clk_switch_done),
    .sys_rst         (sys_rst),
    .in_sleep        (in_sleep),
    .flag_clr        (flag_clr),
    .rst_req         (rst_req),
    .wake_req        (wake_req),
    .timeout_flag    (timeout_flag)
  );

  typedef struct {
    int    kind;
    int    at;
    string req;
  } exp_t;

  exp_t sb[$];
  int   cyc    = 0;
  int   n_chk  = 0;
  int   n_fail = 0;
  int   n_evt  = 0;
  bit   done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_evt(int kind, int at, string req);
    sb.push_back('{kind, at, req});
  endtask

  // Monitor: pops the scoreboard as requests appear.
  exp_t got_e;
  int   got_kind;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rst_req || wake_req) begin
        n_evt++;
        n_chk++;
        got_kind = wake_req ? K_WAKE : K_RST;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R4 R9: unexpected request kind %0d at cycle %0d, expected none",
                   got_kind, cyc);
        end else begin
          got_e = sb.pop_front();
          if (got_e.kind != got_kind || got_e.at != cyc) begin
            n_fail++;
            $display("FAIL %s: request kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                     got_e.req, got_kind, cyc, got_e.kind, got_e.at);
          end
        end
      end else if (sb.size() > 0 && sb[0].at < cyc) begin
        got_e = sb.pop_front();
        n_chk++;
        n_fail++;
        $display("FAIL %s: no request at cycle %0d, expected kind %0d", got_e.req,
                 got_e.at, got_e.kind);
      end
    end
  end

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // which: 0 clr, 1 pwrsave, 2 sleep exit, 3 clock switch, 4 sys reset, 5 flag clear
  task automatic pulse(int which);
    case (which)
      0: clr_cmd = 1'b1;
      1: pwrsave_enter = 1'b1;
      2: sleep_exit = 1'b1;
      3: clk_switch_done = 1'b1;
      4: sys_rst = 1'b1;
      default: flag_clr = 1'b1;
    endcase
    @(negedge clk);
    clr_cmd = 1'b0; pwrsave_enter = 1'b0; sleep_exit = 1'b0;
    clk_switch_done = 1'b0; sys_rst = 1'b0; flag_clr = 1'b0;
  endtask

  // Software enable; m is the cycle after which the count is zero.
  task automatic sw_on(output int m);
    int c;
    c = cyc;
    sw_en_wr = 1'b1; sw_en_val = 1'b1;
    @(negedge clk);
    sw_en_wr = 1'b0;
    m = c + 1;
  endtask

  task automatic stop_all();
    cfg_hw_en = 1'b0;
    pulse(4);
    idle(2);
  endtask

  initial begin
    int m, m2, m3, m4, m5, m6, base;
    rst_n = 1'b0; tick_en = 1'b1; cfg_long_pre = 1'b0; cfg_post_sel = '0;
    cfg_hw_en = 1'b0; cfg_win_off = 1'b1; sw_en_wr = 1'b0; sw_en_val = 1'b0;
    clr_cmd = 1'b0; pwrsave_enter = 1'b0; sleep_exit = 1'b0; clk_switch_done = 1'b0;
    sys_rst = 1'b0; in_sleep = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk("R10", rst_req, 0);
    chk("R10", wake_req, 0);
    chk("R10", timeout_flag, 0);

    // R4: disabled, even an early clear in window mode does nothing
    cfg_win_off = 1'b0;
    idle(60);
    pulse(0);
    idle(60);
    chk("R4", n_evt, 0);
    cfg_win_off = 1'b1;

    // R6, R1 short divide, R8 flag
    sw_on(m);
    expect_evt(K_RST, m + 32, "R6");
    wait_to(m + 34);
    chk("R8", timeout_flag, 1);
    pulse(4);
    // R5: system reset cleared the software enable, so nothing more arrives
    idle(80);
    chk("R5", n_evt, 1);
    chk("R8", timeout_flag, 1);
    pulse(5);
    chk("R8", timeout_flag, 0);

    // R6: timeout in sleep wakes instead of resetting
    in_sleep = 1'b1;
    sw_on(m);
    expect_evt(K_WAKE, m + 32, "R6");
    wait_to(m + 33);
    chk("R8", timeout_flag, 1);
    stop_all();
    in_sleep = 1'b0;
    pulse(5);

    // R2: postscale 4
    cfg_post_sel = 4'd2;
    sw_on(m);
    expect_evt(K_RST, m + 128, "R2");
    wait_to(m + 130);
    stop_all();

    // R1: long prescale, postscale 1 and 2
    cfg_long_pre = 1'b1; cfg_post_sel = 4'd0;
    sw_on(m);
    expect_evt(K_RST, m + 128, "R1");
    wait_to(m + 130);
    stop_all();
    cfg_post_sel = 4'd1;
    sw_on(m);
    expect_evt(K_RST, m + 256, "R1");
    wait_to(m + 258);
    stop_all();
    cfg_long_pre = 1'b0; cfg_post_sel = 4'd0;

    // R2: gated ticks do not count
    sw_on(m);
    wait_to(m + 5);
    tick_en = 1'b0;
    idle(10);
    tick_en = 1'b1;
    expect_evt(K_RST, m + 42, "R2");
    wait_to(m + 44);
    stop_all();

    // R3: each restart source; window off so an early clear only restarts (R7)
    sw_on(m);
    wait_to(m + 20); pulse(1); m2 = m + 21;
    wait_to(m2 + 10); pulse(2); m3 = m2 + 11;
    wait_to(m3 + 10); pulse(3); m4 = m3 + 11;
    expect_evt(K_RST, m4 + 32, "R3");
    m5 = m4 + 32;
    wait_to(m5 + 10); pulse(0); m6 = m5 + 11;
    expect_evt(K_RST, m6 + 32, "R7");
    wait_to(m6 + 33);
    stop_all();

    // R4 hardware enable; R3 system reset restarts but does not stop it
    base = cyc;
    cfg_hw_en = 1'b1;
    m = base;
    wait_to(m + 20); pulse(4); m2 = m + 21;
    expect_evt(K_RST, m2 + 32, "R3");
    wait_to(m2 + 33);
    cfg_hw_en = 1'b0;
    idle(3);

    // R9: clear on the terminal tick wins (window on, clear is legal)
    cfg_win_off = 1'b0;
    pulse(5);
    sw_on(m);
    wait_to(m + 31); pulse(0);
    expect_evt(K_RST, m + 64, "R9");
    wait_to(m + 63);
    chk("R9", timeout_flag, 0);
    wait_to(m + 65);
    stop_all();

    // R7: window boundary at 24 of 32
    sw_on(m);
    wait_to(m + 23);
    expect_evt(K_RST, m + 24, "R7");
    pulse(0); m2 = m + 24;
    wait_to(m2 + 24); pulse(0); m3 = m2 + 25;
    expect_evt(K_RST, m3 + 32, "R7");
    wait_to(m3 + 33);
    stop_all();

    // R7: window boundary at 96 of 128
    cfg_post_sel = 4'd2;
    sw_on(m);
    wait_to(m + 95);
    expect_evt(K_RST, m + 96, "R7");
    pulse(0); m2 = m + 96;
    wait_to(m2 + 96); pulse(0); m3 = m2 + 97;
    expect_evt(K_RST, m3 + 128, "R7");
    wait_to(m3 + 129);
    stop_all();
    cfg_post_sel = 4'd0; cfg_win_off = 1'b1;

    idle(5);
    chk("R3", sb.size(), 0);
    finish_up();
  end

endmodule